// File: doc/BRIEF.md
# Flash Sleep and Wake Controller

This block governs the low-power state of an embedded flash macro. It takes command words from a command port. It also takes read requests from a small set of requesters, for example the cache, DMA reads, the CPU and other peripherals. From these it decides when the macro sleeps, when it wakes and when reads may proceed. A sleep command puts the macro into sleep. Any read request, or an idle or abort command, starts a wake-up. That wake-up holds off all reads and commands for a fixed number of core clock cycles.

While the macro sleeps, the block masks the clock-gate enable for most of the surrounding controller. It stalls DMA writes and drops every command except idle and abort. A system-interrupt abort sets the abort status while the macro is awake but never wakes it. A hibernation handshake tells the power manager when no read is in flight. The block passes through all commands that are neither sleep, idle nor abort, so that the program and erase logic can execute them.

Top module: `flash_doze_ctrl`

## Requirements
- R1: After reset the macro is awake: `flash_sleep`=0, `clk_en`=1, `status`=0, `cmd_ready`=1 and no grant is given.
- R2: A command with code 1 (sleep), when accepted while awake, makes `flash_sleep`=1, `clk_en`=0 and `status[6]`=1 from the next cycle.
- R3: While asleep, any asserted bit of `rd_req` starts a wake-up. From the next cycle `flash_sleep`=0 and `clk_en`=1. No grant is given for WAKE_CYC cycles, and the held request is granted in the cycle after that.
- R4: While asleep, every command code other than 0 and 2 is accepted and dropped. The macro stays asleep and `fwd_valid` stays 0.
- R5: While asleep, command code 0 (idle) starts the same wake-up as R3 and leaves `status[5:4]` at 00.
- R6: An accepted command with code 2 (abort) sets `status[5:4]` to 11 from the next cycle. When it arrives while asleep it also starts the wake-up. The field returns to 00 after the next forwarded command.
- R7: A pulse on `sys_abort` never wakes a sleeping macro. While awake it sets `status[5:4]` to 11.
- R8: `dma_wr_stall` follows `dma_wr_req` whenever the macro is asleep or waking, and is 0 while awake.
- R9: `cmd_ready` is 0 while waking and while a read is in progress. A command with code 3 or above, accepted while awake, appears on `fwd_valid`/`fwd_code` in the same cycle.
- R10: While awake and idle, at most one grant is given per read. It goes to the lowest-indexed requester. A valid command in the same cycle takes precedence, and the next grant comes RD_CYC+1 cycles after the previous one.
- R11: `hib_ack` follows `hib_req` only while no read is in progress. No new read is granted while `hib_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command word present |
| cmd_code | input | CW | Command code (0 idle, 1 sleep, 2 abort, others forwarded) |
| cmd_ready | output | 1 | Command accepted this cycle when valid |
| fwd_valid | output | 1 | Forwarded command strobe |
| fwd_code | output | CW | Forwarded command code |
| sys_abort | input | 1 | Abort raised by an enabled system interrupt |
| rd_req | input | NREQ | Read requests, held until granted |
| rd_gnt | output | NREQ | One-hot read grant |
| dma_wr_req | input | 1 | DMA write request |
| dma_wr_stall | output | 1 | DMA write stall |
| flash_sleep | output | 1 | Sleep enable to the flash macro |
| clk_en | output | 1 | Clock-gate enable for the non-essential logic |
| status | output | 7 | Bit 6 asleep, bits 5:4 abort code, bits 3:0 zero |
| hib_req | input | 1 | Hibernation request from the power manager |
| hib_ack | output | 1 | Hibernation allowed |

## Verification
Two functions can coincide in one cycle. An abort command can arrive in the same cycle as a read request that is itself waking the macro. A forwarded command can also meet a read request on an awake macro. The bench drives each pair on a single falling edge. For the wake case it expects exactly one wake-up of WAKE_CYC cycles, abort status 11 and the read granted afterwards. For the awake case it expects the command forwarded, no grant in that cycle and the read granted in the cycle after.

// File: rtl/flash_doze_ctrl.sv
module flash_doze_ctrl #(
  parameter int NREQ     = 4,
  parameter int CW       = 4,
  parameter int WAKE_CYC = 130,
  parameter int RD_CYC   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic [CW-1:0]   cmd_code,
  output logic            cmd_ready,
  output logic            fwd_valid,
  output logic [CW-1:0]   fwd_code,
  input  logic            sys_abort,
  input  logic [NREQ-1:0] rd_req,
  output logic [NREQ-1:0] rd_gnt,
  input  logic            dma_wr_req,
  output logic            dma_wr_stall,
  output logic            flash_sleep,
  output logic            clk_en,
  output logic [6:0]      status,
  input  logic            hib_req,
  output logic            hib_ack
);
  localparam int WW = $clog2(WAKE_CYC + 1);
  localparam int RW = $clog2(RD_CYC + 1);
  localparam logic [CW-1:0] OP_IDLE  = CW'(0);
  localparam logic [CW-1:0] OP_SLEEP = CW'(1);
  localparam logic [CW-1:0] OP_ABORT = CW'(2);

  typedef enum logic [1:0] {AWAKE, ASLEEP, WAKING} st_t;

  st_t           st;
  logic [WW-1:0] wcnt;
  logic [RW-1:0] bcnt;
  logic [1:0]    abrt;
  logic          busy, taken, is_idle, is_sleep, is_abort, wake_go, abort_set;
  logic [NREQ-1:0] pick;

  assign busy     = |bcnt;
  assign is_idle  = cmd_code == OP_IDLE;
  assign is_sleep = cmd_code == OP_SLEEP;
  assign is_abort = cmd_code == OP_ABORT;

  assign cmd_ready = (st == ASLEEP) || (st == AWAKE && !busy);
  assign taken     = cmd_valid && cmd_ready;
  assign fwd_valid = taken && st == AWAKE && !is_idle && !is_sleep && !is_abort;
  assign fwd_code  = cmd_code;

  assign wake_go   = st == ASLEEP && ((taken && (is_idle || is_abort)) || |rd_req);
  assign abort_set = (taken && is_abort) || (st == AWAKE && sys_abort);

  always_comb begin
    pick = '0;
    for (int i = NREQ - 1; i >= 0; i--)
      if (rd_req[i]) pick = NREQ'(1) << i;
  end

  assign rd_gnt = (st == AWAKE && !busy && !cmd_valid && !hib_req) ? pick : '0;

  assign flash_sleep  = st == ASLEEP;
  assign clk_en       = st != ASLEEP;
  assign dma_wr_stall = dma_wr_req && st != AWAKE;
  assign status       = {st == ASLEEP, abrt, 4'b0000};
  assign hib_ack      = hib_req && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= AWAKE;
      wcnt <= '0;
    end else begin
      unique case (st)
        AWAKE:  if (taken && is_sleep) st <= ASLEEP;
        ASLEEP: if (wake_go) begin
                  st   <= WAKING;
                  wcnt <= WW'(WAKE_CYC - 1);
                end
        WAKING: if (wcnt == '0) st <= AWAKE;
                else wcnt <= wcnt - 1'b1;
        default: st <= AWAKE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          bcnt <= '0;
    else if (|rd_gnt)    bcnt <= RW'(RD_CYC);
    else if (busy)       bcnt <= bcnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         abrt <= 2'b00;
    else if (abort_set) abrt <= 2'b11;
    else if (fwd_valid) abrt <= 2'b00;
  end
endmodule

// File: rtl/flash_doze_ctrl_chk.sv
module flash_doze_ctrl_chk #(
  parameter int NREQ = 4,
  parameter int CW   = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_valid,
  input logic [CW-1:0]   cmd_code,
  input logic            cmd_ready,
  input logic            fwd_valid,
  input logic            sys_abort,
  input logic [NREQ-1:0] rd_req,
  input logic [NREQ-1:0] rd_gnt,
  input logic            dma_wr_req,
  input logic            dma_wr_stall,
  input logic            flash_sleep,
  input logic [2:0]      stat,
  input logic            hib_req,
  input logic            hib_ack
);
  a_r2_sleep_entry: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && cmd_code == CW'(1) && !stat[2] |=> stat[2] && flash_sleep);

  a_r3_no_grant_asleep: assert property (@(posedge clk) disable iff (!rst_n)
    stat[2] |-> rd_gnt == '0);

  a_r4_ignored_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    stat[2] && rd_req == '0 && !(cmd_valid && (cmd_code == CW'(0) || cmd_code == CW'(2)))
    |=> stat[2]);

  a_r6_abort_status: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && cmd_code == CW'(2) |=> stat[1:0] == 2'b11);

  a_r7_irq_no_wake: assert property (@(posedge clk) disable iff (!rst_n)
    stat[2] && sys_abort && !cmd_valid && rd_req == '0 |=> stat[2]);

  a_r8_dma_stall: assert property (@(posedge clk) disable iff (!rst_n)
    dma_wr_req && flash_sleep |-> dma_wr_stall);

  a_r9_fwd_accepted: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> cmd_valid && cmd_ready && !flash_sleep);

  a_r10_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd_gnt) && (rd_gnt & ~rd_req) == '0);

  a_r11_hib_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (hib_req |-> rd_gnt == '0) and (hib_ack |-> hib_req));
endmodule

bind flash_doze_ctrl flash_doze_ctrl_chk #(.NREQ(NREQ), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
  .cmd_ready(cmd_ready), .fwd_valid(fwd_valid), .sys_abort(sys_abort),
  .rd_req(rd_req), .rd_gnt(rd_gnt), .dma_wr_req(dma_wr_req),
  .dma_wr_stall(dma_wr_stall), .flash_sleep(flash_sleep), .stat(status[6:4]),
  .hib_req(hib_req), .hib_ack(hib_ack));

// File: tb/flash_doze_ctrl_test.sv
`timescale 1ns/1ps
module flash_doze_ctrl_test;
  localparam int NREQ = 4, CW = 4, WK = 6, RD = 3;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, sys_abort = 0, dma_wr_req = 0, hib_req = 0;
  logic [CW-1:0] cmd_code = '0;
  logic [NREQ-1:0] rd_req = '0;
  logic cmd_ready, fwd_valid, dma_wr_stall, flash_sleep, clk_en, hib_ack;
  logic [CW-1:0] fwd_code;
  logic [NREQ-1:0] rd_gnt;
  logic [6:0] status;
  int checks = 0, fails = 0, cyc = 0;
  int fwd_seen, fwd_c;

  always #10 clk = ~clk;

  flash_doze_ctrl #(.NREQ(NREQ), .CW(CW), .WAKE_CYC(WK), .RD_CYC(RD)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_ready(cmd_ready), .fwd_valid(fwd_valid), .fwd_code(fwd_code),
    .sys_abort(sys_abort), .rd_req(rd_req), .rd_gnt(rd_gnt),
    .dma_wr_req(dma_wr_req), .dma_wr_stall(dma_wr_stall),
    .flash_sleep(flash_sleep), .clk_en(clk_en), .status(status),
    .hib_req(hib_req), .hib_ack(hib_ack));

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic issue(input int c);
    @(negedge clk); cmd_valid = 1; cmd_code = c[CW-1:0]; #1;
    fwd_seen = int'(fwd_valid); fwd_c = int'(fwd_code);
    @(negedge clk); cmd_valid = 0; #1;
  endtask

  task automatic go_sleep();
    issue(1);
    chk("R2 flash_sleep", int'(flash_sleep), 1);
    chk("R2 status6", int'(status[6]), 1);
    chk("R2 clk_en", int'(clk_en), 0);
  endtask

  // called one cycle after the wake trigger; leaves at the first awake cycle
  task automatic ride_wake(input string r);
    for (int k = 0; k < WK; k++) begin
      chk({r, " no grant while waking"}, int'(rd_gnt), 0);
      chk("R9 ready low while waking", int'(cmd_ready), 0);
      chk({r, " clk_en on"}, int'(clk_en), 1);
      @(negedge clk); #1;
    end
    chk("R9 ready after wake", int'(cmd_ready), 1);
  endtask

  task automatic idle_wait(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
    #1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    idle_wait(2);
    rst_n = 1;
    idle_wait(1);
    chk("R1 flash_sleep", int'(flash_sleep), 0);
    chk("R1 clk_en", int'(clk_en), 1);
    chk("R1 status", int'(status), 0);
    chk("R1 cmd_ready", int'(cmd_ready), 1);
    chk("R1 grant", int'(rd_gnt), 0);

    // sweep every command code against a sleeping macro
    for (int c = 0; c < 16; c++) begin
      go_sleep();
      issue(c);
      chk("R4 no forward asleep", fwd_seen, 0);
      if (c == 0 || c == 2) begin
        chk("R5 R6 wake by command", int'(flash_sleep), 0);
        chk("R5 R6 abort field", int'(status[5:4]), (c == 2) ? 3 : 0);
        ride_wake("R5");
      end else begin
        chk("R4 stays asleep", int'(status[6]), 1);
        issue(0);
        ride_wake("R5");
      end
      issue(5);
      chk("R9 forward strobe", fwd_seen, 1);
      chk("R9 forward code", fwd_c, 5);
      chk("R6 cleared by forward", int'(status[5:4]), 0);
    end

    // wake by each requester, with DMA write stall watched
    for (int i = 0; i < NREQ; i++) begin
      go_sleep();
      @(negedge clk); dma_wr_req = 1; #1;
      chk("R8 stall asleep", int'(dma_wr_stall), 1);
      rd_req = NREQ'(1) << i;
      @(negedge clk); #1;
      chk("R3 awake level", int'(flash_sleep), 0);
      chk("R8 stall waking", int'(dma_wr_stall), 1);
      ride_wake("R3");
      chk("R3 grant after latency", int'(rd_gnt), 1 << i);
      chk("R8 no stall awake", int'(dma_wr_stall), 0);
      @(negedge clk); rd_req = '0; dma_wr_req = 0;
      idle_wait(RD + 1);
    end

    // system-interrupt abort
    go_sleep();
    @(negedge clk); sys_abort = 1;
    @(negedge clk); sys_abort = 0; #1;
    chk("R7 stays asleep", int'(status[6]), 1);
    chk("R7 no abort field asleep", int'(status[5:4]), 0);
    issue(0);
    ride_wake("R5");
    @(negedge clk); sys_abort = 1;
    @(negedge clk); sys_abort = 0; #1;
    chk("R7 abort field awake", int'(status[5:4]), 3);
    issue(7);
    chk("R6 cleared", int'(status[5:4]), 0);

    // grant priority and spacing
    @(negedge clk); rd_req = 4'b1010; #1;
    chk("R10 lowest index", int'(rd_gnt), 2);
    @(negedge clk); rd_req = 4'b1000; #1;
    for (int k = 0; k < RD; k++) begin
      chk("R10 busy gap", int'(rd_gnt), 0);
      chk("R9 ready low busy", int'(cmd_ready), 0);
      @(negedge clk); #1;
    end
    chk("R10 next grant", int'(rd_gnt), 8);
    @(negedge clk); rd_req = '0;
    idle_wait(RD + 1);

    // command and read in the same awake cycle
    @(negedge clk); rd_req = 4'b0001; cmd_valid = 1; cmd_code = 4'd9; #1;
    chk("R10 command wins", int'(rd_gnt), 0);
    chk("R9 forwarded", int'(fwd_valid), 1);
    @(negedge clk); cmd_valid = 0; #1;
    chk("R10 read after command", int'(rd_gnt), 1);
    @(negedge clk); rd_req = '0;
    idle_wait(RD + 1);

    // hibernation handshake
    @(negedge clk); rd_req = 4'b0001; #1;
    chk("R11 grant", int'(rd_gnt), 1);
    @(negedge clk); rd_req = 4'b0010; hib_req = 1; #1;
    for (int k = 0; k < RD; k++) begin
      chk("R11 ack held", int'(hib_ack), 0);
      @(negedge clk); #1;
    end
    chk("R11 ack", int'(hib_ack), 1);
    chk("R11 no grant during request", int'(rd_gnt), 0);
    @(negedge clk); hib_req = 0; #1;
    chk("R11 grant after release", int'(rd_gnt), 2);
    @(negedge clk); rd_req = '0;
    idle_wait(RD + 1);

    // abort and read waking in the same cycle
    go_sleep();
    @(negedge clk); cmd_valid = 1; cmd_code = 4'd2; rd_req = 4'b0100;
    @(negedge clk); cmd_valid = 0; #1;
    chk("R6 abort field on joint wake", int'(status[5:4]), 3);
    chk("R3 joint wake", int'(flash_sleep), 0);
    ride_wake("R3");
    chk("R3 joint grant", int'(rd_gnt), 4);
    @(negedge clk); rd_req = '0;
    idle_wait(RD + 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule